// File: doc/BRIEF.md
# Temperature Event Interrupt Controller

This block sits behind a two-zone temperature converter. Each time a conversion pair completes, it receives one 8-bit local reading and one 12-bit remote reading. It compares them against a critical limit, a high limit and a low limit for each zone. It also takes a remote-sensor fault flag. Events are collected in a sticky 8-bit status register, which is cleared by a read strobe. The block drives an active-low interrupt request. Software can poll the status register, or let the interrupt line request service.

High and low limit checks are filtered by a consecutive-conversion counter. The depth of that counter can be selected. Most event classes disarm themselves by clearing their own mask bit when they fire, so they need to be re-armed after servicing. The two critical events leave their mask bits alone. The interrupt line is held inactive whenever the global enable is low.

Top module: `temp_irq_ctrl`

## Requirements
- R1: Every cycle with `conv_done_i` high sets status bit 7 (data ready) and clears mask bit 7.
- R2: A conversion with remote reading strictly greater than `remote_crit_i` sets bit 1. A conversion with local reading strictly greater than `local_crit_i` sets bit 0. Neither of these changes any mask bit.
- R3: A qualified remote reading strictly above `remote_hi_i` sets bit 4 and clears mask bit 4. A qualified local reading strictly above `local_hi_i` sets bit 6 and clears mask bit 6. The remote compare uses all 12 bits.
- R4: A qualified remote reading strictly below `remote_lo_i` sets bit 3 and clears mask bit 3. A qualified local reading strictly below `local_lo_i` sets bit 5 and clears mask bit 5.
- R5: A conversion with `diode_fault_i` high sets bit 2 and clears mask bit 2.
- R6: Each of the four high/low checks is qualified only once its condition has held for N consecutive conversions, where `qdepth_i` 0,1,2,3 selects N = 1,2,4,6. The check keeps firing on every conversion while the condition stays true. A conversion with the condition false restarts its count.
- R7: Status bits are sticky, and repeated events show as one set bit. A `stat_rd_i` pulse clears the status in the next cycle, except for bits set by events in that same cycle.
- R8: While `irq_en_i` is 0, `irq_no` stays 1.
- R9: With `irq_en_i` at 1, `irq_no` is 0 exactly when some event since the last read was recorded while its mask bit was 1. The line returns to 1 after a status read.
- R10: After reset, status is 0, mask is all ones and `irq_no` is 1. `mask_wr_i` loads `mask_i`, but event-driven mask clears in the same cycle take priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion pair complete strobe |
| local_temp_i | input | 8 | Local zone reading |
| remote_temp_i | input | 12 | Remote zone reading |
| local_crit_i | input | 8 | Local critical limit |
| local_hi_i | input | 8 | Local high limit |
| local_lo_i | input | 8 | Local low limit |
| remote_crit_i | input | 12 | Remote critical limit |
| remote_hi_i | input | 12 | Remote high limit |
| remote_lo_i | input | 12 | Remote low limit |
| diode_fault_i | input | 1 | Remote sensor open or shorted |
| qdepth_i | input | 2 | Fault queue depth select |
| mask_wr_i | input | 1 | Mask load strobe |
| mask_i | input | 8 | Mask load value |
| irq_en_i | input | 1 | Global interrupt enable |
| stat_rd_i | input | 1 | Status read strobe (clears) |
| status_o | output | 8 | Sticky event status |
| mask_o | output | 8 | Current mask bits |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The directed part places readings exactly on each limit and one count past it. This separates strict compares from inclusive ones. It uses remote values whose low byte wraps, which shows whether all 12 bits are compared. Runs of conversions above a high limit, broken by a single in-range reading, separate a per-check consecutive counter from a cumulative or shared one. A random phase varies the readings around the limits, along with reads, mask writes, enable and queue depth. Its purpose is to separate latching the mask at event time from gating by the current mask, and to separate sticky merging from overwriting.

// File: rtl/temp_irq_pkg.sv
package temp_irq_pkg;
  localparam int ST_W     = 8;
  localparam int B_RDY    = 7;
  localparam int B_LHI    = 6;
  localparam int B_LLO    = 5;
  localparam int B_RHI    = 4;
  localparam int B_RLO    = 3;
  localparam int B_DIODE  = 2;
  localparam int B_RCRIT  = 1;
  localparam int B_LCRIT  = 0;
  localparam logic [ST_W-1:0] SELF_DISARM = 8'hFC;

  function automatic logic [2:0] qdepth_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/temp_fault_queue.sv
module temp_fault_queue #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             cond_i,
  input  logic [CNT_W-1:0] depth_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire_o  = conv_i && cond_i && (cnt_inc >= {1'b0, depth_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (conv_i) begin
      if (!cond_i)          cnt_q <= '0;
      else if (cnt_q < depth_i) cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/temp_zone_chk.sv
module temp_zone_chk #(
  parameter int W     = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic [W-1:0]     temp_i,
  input  logic [W-1:0]     crit_i,
  input  logic [W-1:0]     hi_i,
  input  logic [W-1:0]     lo_i,
  input  logic [CNT_W-1:0] depth_i,
  output logic             crit_o,
  output logic             hi_o,
  output logic             lo_o
);
  logic [1:0] cond;
  logic [1:0] fire;

  assign crit_o  = conv_i && (temp_i > crit_i);
  assign cond[0] = temp_i > hi_i;
  assign cond[1] = temp_i < lo_i;

  for (genvar k = 0; k < 2; k++) begin : g_q
    temp_fault_queue #(.CNT_W(CNT_W)) i_q (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .conv_i (conv_i),
      .cond_i (cond[k]),
      .depth_i(depth_i),
      .fire_o (fire[k])
    );
  end

  assign hi_o = fire[0];
  assign lo_o = fire[1];
endmodule

// File: rtl/temp_irq_ctrl.sv
module temp_irq_ctrl
  import temp_irq_pkg::*;
#(
  parameter int LT_W = 8,
  parameter int RT_W = 12,
  parameter logic [ST_W-1:0] MASK_RST = 8'hFF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            conv_done_i,
  input  logic [LT_W-1:0] local_temp_i,
  input  logic [RT_W-1:0] remote_temp_i,
  input  logic [LT_W-1:0] local_crit_i,
  input  logic [LT_W-1:0] local_hi_i,
  input  logic [LT_W-1:0] local_lo_i,
  input  logic [RT_W-1:0] remote_crit_i,
  input  logic [RT_W-1:0] remote_hi_i,
  input  logic [RT_W-1:0] remote_lo_i,
  input  logic            diode_fault_i,
  input  logic [1:0]      qdepth_i,
  input  logic            mask_wr_i,
  input  logic [ST_W-1:0] mask_i,
  input  logic            irq_en_i,
  input  logic            stat_rd_i,
  output logic [ST_W-1:0] status_o,
  output logic [ST_W-1:0] mask_o,
  output logic            irq_no
);
  localparam int CNT_W = 3;

  logic [CNT_W-1:0] depth;
  logic             l_crit, l_hi, l_lo, r_crit, r_hi, r_lo;
  logic [ST_W-1:0]  ev;
  logic [ST_W-1:0]  status_q, mask_q, pend_q;

  assign depth = qdepth_decode(qdepth_i);

  temp_zone_chk #(.W(LT_W), .CNT_W(CNT_W)) i_local (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_done_i),
    .temp_i(local_temp_i), .crit_i(local_crit_i), .hi_i(local_hi_i), .lo_i(local_lo_i),
    .depth_i(depth), .crit_o(l_crit), .hi_o(l_hi), .lo_o(l_lo)
  );

  temp_zone_chk #(.W(RT_W), .CNT_W(CNT_W)) i_remote (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_done_i),
    .temp_i(remote_temp_i), .crit_i(remote_crit_i), .hi_i(remote_hi_i), .lo_i(remote_lo_i),
    .depth_i(depth), .crit_o(r_crit), .hi_o(r_hi), .lo_o(r_lo)
  );

  always_comb begin
    ev          = '0;
    ev[B_RDY]   = conv_done_i;
    ev[B_LHI]   = l_hi;
    ev[B_LLO]   = l_lo;
    ev[B_RHI]   = r_hi;
    ev[B_RLO]   = r_lo;
    ev[B_DIODE] = conv_done_i && diode_fault_i;
    ev[B_RCRIT] = r_crit;
    ev[B_LCRIT] = l_crit;
  end

  // pend_q latches mask state at event time; cleared with status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      pend_q   <= '0;
      mask_q   <= MASK_RST;
    end else begin
      status_q <= (stat_rd_i ? '0 : status_q) | ev;
      pend_q   <= (stat_rd_i ? '0 : pend_q) | (ev & mask_q);
      mask_q   <= (mask_wr_i ? mask_i : mask_q) & ~(ev & SELF_DISARM);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_no   = !(irq_en_i && (|pend_q));
endmodule

// File: rtl/temp_irq_ctrl_chk.sv
module temp_irq_ctrl_chk #(
  parameter int LT_W = 8,
  parameter int RT_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            conv_done_i,
  input logic [LT_W-1:0] local_temp_i,
  input logic [RT_W-1:0] remote_temp_i,
  input logic [LT_W-1:0] local_crit_i,
  input logic [LT_W-1:0] local_hi_i,
  input logic [LT_W-1:0] local_lo_i,
  input logic [RT_W-1:0] remote_crit_i,
  input logic [RT_W-1:0] remote_hi_i,
  input logic [RT_W-1:0] remote_lo_i,
  input logic            diode_fault_i,
  input logic [1:0]      qdepth_i,
  input logic            mask_wr_i,
  input logic [7:0]      mask_i,
  input logic            irq_en_i,
  input logic            stat_rd_i,
  input logic [7:0]      status_o,
  input logic [7:0]      mask_o,
  input logic            irq_no
);
  // R1
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> status_o[7]);
  // R1
  rdy_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> !mask_o[7]);
  // R2
  crit_mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_i |=> mask_o[1:0] == $past(mask_o[1:0]));
  // R10
  mask_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_i |=> (mask_o & ~$past(mask_o)) == 8'h00);
  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_rd_i && !conv_done_i) |=> status_o == $past(status_o));
  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !conv_done_i) |=> status_o == 8'h00);
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> irq_no);
  // R9
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (status_o != 8'h00));
endmodule

bind temp_irq_ctrl temp_irq_ctrl_chk #(.LT_W(LT_W), .RT_W(RT_W)) i_chk (.*);

// File: tb/test_temp_irq_ctrl.sv
module test_temp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv = 1'b0;
  logic [7:0]  l_t = '0, l_crit = '0, l_hi = '0, l_lo = '0;
  logic [11:0] r_t = '0, r_crit = '0, r_hi = '0, r_lo = '0;
  logic        dfault = 1'b0, wr = 1'b0, en = 1'b0, rd = 1'b0;
  logic [1:0]  qd = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  status, mask;
  logic        irq_n;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] e_status = 8'h00, e_mask = 8'hFF, e_pend = 8'h00;
  int e_cnt [4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  temp_irq_ctrl i_temp_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(conv),
    .local_temp_i(l_t), .remote_temp_i(r_t),
    .local_crit_i(l_crit), .local_hi_i(l_hi), .local_lo_i(l_lo),
    .remote_crit_i(r_crit), .remote_hi_i(r_hi), .remote_lo_i(r_lo),
    .diode_fault_i(dfault), .qdepth_i(qd), .mask_wr_i(wr), .mask_i(wdata),
    .irq_en_i(en), .stat_rd_i(rd),
    .status_o(status), .mask_o(mask), .irq_no(irq_n)
  );

  function automatic int depth_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] ev = 8'h00;
    logic cond [4];
    logic fire [4];
    int d = depth_of(qd);
    if (conv) begin
      ev[7] = 1'b1;
      ev[1] = r_t > r_crit;
      ev[0] = l_t > l_crit;
      ev[2] = dfault;
      cond[0] = r_t > r_hi; cond[1] = r_t < r_lo;
      cond[2] = l_t > l_hi; cond[3] = l_t < l_lo;
      for (int k = 0; k < 4; k++) begin
        if (cond[k]) begin
          if (e_cnt[k] < d) e_cnt[k]++;
          fire[k] = e_cnt[k] >= d;
        end else begin
          e_cnt[k] = 0;
          fire[k] = 1'b0;
        end
      end
      ev[4] = fire[0]; ev[3] = fire[1]; ev[6] = fire[2]; ev[5] = fire[3];
    end
    e_pend   = (rd ? 8'h00 : e_pend) | (ev & e_mask);
    e_status = (rd ? 8'h00 : e_status) | ev;
    e_mask   = (wr ? wdata : e_mask) & ~(ev & 8'hFC);
  endtask

  task automatic check_all(input string req);
    chk(req, "status", status, e_status);
    chk(req, "mask", mask, e_mask);
    chk(req, "irq_n", irq_n, !(en && (e_pend != 8'h00)));
  endtask

  // inputs set by caller before the negedge-aligned call
  task automatic step(input string req);
    @(posedge clk);
    model_step();
    #1;
    check_all(req);
    @(negedge clk);
    conv = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic conv_at(input logic [7:0] lt, input logic [11:0] rt, input string req);
    l_t = lt; r_t = rt; conv = 1'b1;
    step(req);
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected below 200000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    l_crit = 8'd90; l_hi = 8'd80; l_lo = 8'd50;
    r_crit = 12'h300; r_hi = 12'h100; r_lo = 12'h080;
    l_t = 8'd60; r_t = 12'h0C0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "reset status", status, 8'h00);
    chk("R10", "reset mask", mask, 8'hFF);
    chk("R10", "reset irq_n", irq_n, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // interrupt disabled: ready recorded, line quiet
    en = 1'b0;
    conv_at(8'd60, 12'h0C0, "R8");
    chk("R1", "ready bit", status[7], 1);
    chk("R1", "ready mask", mask[7], 0);
    en = 1'b1; #1;
    chk("R9", "late enable irq", irq_n, 0);
    rd = 1'b1; step("R9");
    chk("R7", "cleared status", status, 8'h00);

    // strict boundaries; remote crosses a byte boundary
    conv_at(8'd80, 12'h100, "R3");
    chk("R3", "equal high no event", status[6] | status[4], 0);
    conv_at(8'd90, 12'h101, "R3");
    chk("R3", "remote 12-bit high", status[4], 1);
    chk("R3", "local high", status[6], 1);
    chk("R2", "equal crit none", status[0], 0);
    conv_at(8'd91, 12'h301, "R2");
    chk("R2", "crit bits", status[1:0], 2'b11);
    conv_at(8'd50, 12'h080, "R4");
    chk("R4", "equal low none", status[5] | status[3], 0);
    conv_at(8'd49, 12'h07F, "R4");
    chk("R4", "low bits", {status[5], status[3]}, 2'b11);
    dfault = 1'b1; conv_at(8'd60, 12'h0C0, "R5"); dfault = 1'b0;
    chk("R5", "diode bit", status[2], 1);
    chk("R5", "diode mask", mask[2], 0);

    // mask write colliding with events
    wr = 1'b1; wdata = 8'hFF; rd = 1'b1;
    conv_at(8'd60, 12'h0C0, "R10");
    chk("R10", "write vs disarm", mask, 8'h7F);

    // queue depth 6, broken run restarts
    qd = 2'd3; rd = 1'b1; wr = 1'b1; wdata = 8'hFF; step("R6");
    repeat (4) conv_at(8'd85, 12'h0C0, "R6");
    conv_at(8'd60, 12'h0C0, "R6");
    repeat (5) conv_at(8'd85, 12'h0C0, "R6");
    chk("R6", "depth6 after 5", status[6], 0);
    conv_at(8'd85, 12'h0C0, "R6");
    chk("R6", "depth6 at 6", status[6], 1);
    qd = 2'd1; rd = 1'b1; step("R6");
    conv_at(8'd85, 12'h0C0, "R6");
    chk("R6", "saturated fires", status[6], 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) qd = 2'($urandom_range(0, 3));
      conv   = ($urandom % 2) == 0;
      l_t    = 8'($urandom_range(44, 96));
      r_t    = 12'($urandom_range(12'h070, 12'h310));
      dfault = ($urandom % 10) == 0;
      rd     = ($urandom % 8) == 0;
      wr     = ($urandom % 16) == 0;
      wdata  = 8'($urandom);
      en     = ($urandom % 5) != 0;
      #1;
      chk("R8", "irq gate", (!en && !irq_n) ? 1 : 0, 0);
      step("R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule